// File: doc/BRIEF.md
# Reversible Four-Line Full Adder

This block carries a one-bit full adder on four reversible lines. Three of the lines hold the adder operands. The fourth is an ancilla, a constant-input line that keeps the whole map reversible. The block is purely combinational: every one of the 16 input states maps to a distinct output state. The ancilla's bit position is fixed at elaboration by `ANC_POS`, and each position has its own fixed permutation. When the ancilla input is 0, output bit 1 carries the sum and output bit 0 carries the carry.

A second, independent port pair runs the map backwards: given an output state, it returns the unique input state that produces it. `USE_CASCADE` chooses the structure. With 0, the block is a direct permutation lookup. With 1, it is a fixed chain of two-state exchange stages, each a fully controlled NOT over the bits in which the two states differ. Both structures must give the same map. The operand bits are the three non-ancilla bits, and the block treats them as interchangeable. No meaning is given to the outputs when the ancilla input is 1.

Top module: `rev_fa_core`

## Requirements
- R1: For every legal `ANC_POS` and `USE_CASCADE`, the 16 values of `fwd_o` over all 16 values of `fwd_i` are pairwise distinct.
- R2: With `ANC_POS`=0, `fwd_o` follows the cycles 1→3→4→2→6→5→1, 8→10→13→8, 9→11→12→9 and 14↔15 (decimal states), and states 0 and 7 map to themselves.
- R3: With `ANC_POS`=1, `fwd_o` follows 1↔2, 4→6→7→4, 8↔14, 9→13→11→12→9 and 10↔15, and states 0, 3 and 5 map to themselves.
- R4: With `ANC_POS`=2, `fwd_o` follows 1→2→6→3→1 and 8→10→13→8, and every other state maps to itself.
- R5: When `fwd_i[ANC_POS]` is 0, `fwd_o[1]` equals the XOR of the three other input bits and `fwd_o[0]` equals their majority.
- R6: `sum_o` equals `fwd_o[1]`, `cout_o` equals `fwd_o[0]`, and `fa_valid_o` is 1 exactly when `fwd_i[ANC_POS]` is 0.
- R7: `inv_o` is the unique state whose forward image is `inv_i`. Feeding `fwd_o` into `inv_i` returns `fwd_i` on `inv_o` for all 16 states.
- R8: `USE_CASCADE`=1 gives the same forward and inverse map as `USE_CASCADE`=0 for every `ANC_POS`.
- R9: There is no state or clock. Every output reflects the current inputs in the same cycle, and input 0 always maps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_i | input | 4 | Forward input state; bit `ANC_POS` is the ancilla |
| fwd_o | output | 4 | Forward output state |
| sum_o | output | 1 | Sum (copy of `fwd_o[1]`) |
| cout_o | output | 1 | Carry (copy of `fwd_o[0]`) |
| fa_valid_o | output | 1 | High when the ancilla input is 0 |
| inv_i | input | 4 | Output state to be mapped back |
| inv_o | output | 4 | Input state that produces `inv_i` |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench drives inputs just after a rising edge and samples on the following falling edge, so each value is read half a period after it was applied. A roundtrip check needs two such steps. The bench first samples `fwd_o`, then drives that value into `inv_i` on the next edge and samples `inv_o` on the falling edge after it. Six instances, covering every ancilla position with both structures, are checked against the same expected-value table.

// File: rtl/rev_fa_pkg.sv
package rev_fa_pkg;
  localparam int unsigned W          = 4;
  localparam int unsigned NS         = 1 << W;
  localparam int unsigned MAX_STAGES = 10;
  localparam int unsigned SL_W       = MAX_STAGES * 2 * W;

  typedef logic [W-1:0] state_t;

  // image of state i sits in nibble i
  localparam logic [NS*W-1:0] PERM_P0 = 64'hEF89_CDBA_7512_4630;
  localparam logic [NS*W-1:0] PERM_P1 = 64'hA8B9_CFDE_4756_3120;
  localparam logic [NS*W-1:0] PERM_P2 = 64'hFE8C_BD9A_7354_1620;

  // exchange stage k is byte k = {state_a, state_b}; applied from k=0 upward
  localparam logic [SL_W-1:0] XCHG_P0 = 80'hEF9B_BC8A_AD13_3442_2665;
  localparam logic [SL_W-1:0] XCHG_P1 = 80'h0000_AF9D_DBBC_8E46_6712;
  localparam logic [SL_W-1:0] XCHG_P2 = 80'h0000_0000_008A_AD12_2663;

  function automatic logic [NS*W-1:0] perm_tbl(int unsigned pos);
    case (pos)
      0:       return PERM_P0;
      1:       return PERM_P1;
      default: return PERM_P2;
    endcase
  endfunction

  function automatic state_t fwd_map(int unsigned pos, state_t x);
    logic [NS*W-1:0] t;
    t = perm_tbl(pos);
    return t[int'(x)*W +: W];
  endfunction

  function automatic logic [SL_W-1:0] xchg_list(int unsigned pos);
    case (pos)
      0:       return XCHG_P0;
      1:       return XCHG_P1;
      default: return XCHG_P2;
    endcase
  endfunction

  function automatic int unsigned xchg_count(int unsigned pos);
    case (pos)
      0:       return 10;
      1:       return 8;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/rev_fa_xchg.sv
// swaps two fixed states, passes all others
module rev_fa_xchg
  import rev_fa_pkg::*;
#(
  parameter state_t A = '0,
  parameter state_t B = '0
) (
  input  state_t x_i,
  output state_t y_o
);
  localparam state_t DIFF = A ^ B;

  always_comb begin
    if (x_i == A || x_i == B) y_o = x_i ^ DIFF;
    else                      y_o = x_i;
  end
endmodule

// File: rtl/rev_fa_direct.sv
module rev_fa_direct
  import rev_fa_pkg::*;
#(
  parameter int unsigned POS = 2
) (
  input  state_t fwd_i,
  output state_t fwd_o,
  input  state_t inv_i,
  output state_t inv_o
);
  always_comb fwd_o = fwd_map(POS, fwd_i);

  // inverse by preimage search
  always_comb begin
    inv_o = '0;
    for (int j = 0; j < int'(NS); j++) begin
      if (fwd_map(POS, state_t'(j)) == inv_i) inv_o = state_t'(j);
    end
  end

  always_comb begin
    p_inv_hit_r7: assert (fwd_map(POS, inv_o) == inv_i);
  end
endmodule

// File: rtl/rev_fa_cascade.sv
module rev_fa_cascade
  import rev_fa_pkg::*;
#(
  parameter int unsigned POS = 2
) (
  input  state_t fwd_i,
  output state_t fwd_o,
  input  state_t inv_i,
  output state_t inv_o
);
  localparam int unsigned     NST = xchg_count(POS);
  localparam logic [SL_W-1:0] SL  = xchg_list(POS);

  state_t fc [NST+1];
  state_t ic [NST+1];

  assign fc[0] = fwd_i;
  assign ic[0] = inv_i;

  for (genvar k = 0; k < int'(NST); k++) begin : g_stage
    localparam int KF = k;
    localparam int KR = int'(NST) - 1 - k;
    rev_fa_xchg #(
      .A(SL[KF*2*W+W +: W]),
      .B(SL[KF*2*W   +: W])
    ) i_fwd_xchg (
      .x_i(fc[k]),
      .y_o(fc[k+1])
    );
    // each stage is self-inverse; inverse runs the chain backwards
    rev_fa_xchg #(
      .A(SL[KR*2*W+W +: W]),
      .B(SL[KR*2*W   +: W])
    ) i_inv_xchg (
      .x_i(ic[k]),
      .y_o(ic[k+1])
    );
  end

  assign fwd_o = fc[NST];
  assign inv_o = ic[NST];

  always_comb begin
    p_casc_match_r8: assert (fwd_o == fwd_map(POS, fwd_i));
  end
endmodule

// File: rtl/rev_fa_core.sv
module rev_fa_core
  import rev_fa_pkg::*;
#(
  parameter int unsigned ANC_POS     = 2,
  parameter bit          USE_CASCADE = 1'b0
) (
  input  logic [3:0] fwd_i,
  output logic [3:0] fwd_o,
  output logic       sum_o,
  output logic       cout_o,
  output logic       fa_valid_o,
  input  logic [3:0] inv_i,
  output logic [3:0] inv_o
);
  if (USE_CASCADE) begin : g_casc
    rev_fa_cascade #(.POS(ANC_POS)) i_rev_fa_cascade (
      .fwd_i(fwd_i),
      .fwd_o(fwd_o),
      .inv_i(inv_i),
      .inv_o(inv_o)
    );
  end else begin : g_direct
    rev_fa_direct #(.POS(ANC_POS)) i_rev_fa_direct (
      .fwd_i(fwd_i),
      .fwd_o(fwd_o),
      .inv_i(inv_i),
      .inv_o(inv_o)
    );
  end

  assign sum_o      = fwd_o[1];
  assign cout_o     = fwd_o[0];
  assign fa_valid_o = ~fwd_i[ANC_POS];

  // operand bits: the non-ancilla lines
  logic [2:0] ops;
  always_comb begin
    int idx;
    idx = 0;
    ops = '0;
    for (int b = 0; b < int'(W); b++) begin
      if (b != int'(ANC_POS)) begin
        ops[idx] = fwd_i[b];
        idx++;
      end
    end
  end

  always_comb begin
    if (fa_valid_o) begin
      p_fa_sum_r5:   assert (sum_o == ^ops);
      p_fa_carry_r5: assert (cout_o == ((ops[0] & ops[1]) | (ops[0] & ops[2]) | (ops[1] & ops[2])));
    end
    if (inv_i == fwd_o) begin
      p_roundtrip_r7: assert (inv_o == fwd_i);
    end
  end
endmodule

// File: tb/test_rev_fa_core.sv
module test_rev_fa_core;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_DUT      = 6;
  localparam int  WD_CYCLES  = 20000;

  // expected image of each state, per ancilla position
  localparam logic [3:0] EXP_TBL [3][16] = '{
    '{4'd0, 4'd3, 4'd6, 4'd4, 4'd2, 4'd1, 4'd5, 4'd7, 4'd10, 4'd11, 4'd13, 4'd12, 4'd9, 4'd8, 4'd15, 4'd14},
    '{4'd0, 4'd2, 4'd1, 4'd3, 4'd6, 4'd5, 4'd7, 4'd4, 4'd14, 4'd13, 4'd15, 4'd12, 4'd9, 4'd11, 4'd8, 4'd10},
    '{4'd0, 4'd2, 4'd6, 4'd1, 4'd4, 4'd5, 4'd3, 4'd7, 4'd10, 4'd9, 4'd13, 4'd11, 4'd12, 4'd8, 4'd14, 4'd15}
  };

  logic clk;
  logic rst_n;
  logic [3:0] fi;
  logic [3:0] ii [N_DUT];
  logic [3:0] fo [N_DUT];
  logic [3:0] io [N_DUT];
  logic       so [N_DUT];
  logic       co [N_DUT];
  logic       vo [N_DUT];

  int checks;
  int failures;
  bit done;

  for (genvar p = 0; p < 3; p++) begin : g_pos
    for (genvar c = 0; c < 2; c++) begin : g_impl
      rev_fa_core #(.ANC_POS(p), .USE_CASCADE(c)) i_rev_fa_core (
        .fwd_i     (fi),
        .fwd_o     (fo[p*2+c]),
        .sum_o     (so[p*2+c]),
        .cout_o    (co[p*2+c]),
        .fa_valid_o(vo[p*2+c]),
        .inv_i     (ii[p*2+c]),
        .inv_o     (io[p*2+c])
      );
    end
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(int p);
    case (p)
      0:       return "R2";
      1:       return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [3:0] inv_exp(int p, logic [3:0] y);
    logic [3:0] r;
    r = '0;
    for (int j = 0; j < 16; j++) if (EXP_TBL[p][j] == y) r = 4'(j);
    return r;
  endfunction

  function automatic logic [3:0] put_anc(int p, logic [2:0] ops, logic anc);
    case (p)
      0:       return {ops, anc};
      1:       return {ops[2:1], anc, ops[0]};
      default: return {ops[2], anc, ops[1:0]};
    endcase
  endfunction

  task automatic check(bit ok, string req, int d, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s dut=%0d actual=%0d expected=%0d", req, d, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic drive(logic [3:0] x);
    @(posedge clk);
    fi = x;
    for (int d = 0; d < N_DUT; d++) ii[d] = x;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] seen [N_DUT];
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    fi       = '0;
    for (int d = 0; d < N_DUT; d++) begin
      ii[d]   = '0;
      seen[d] = '0;
    end

    // R9: all-zero state during reset, due without any clock edge
    repeat (2) @(negedge clk);
    for (int d = 0; d < N_DUT; d++) begin
      check(fo[d] == 4'd0, "R9", d, int'(fo[d]), 0);
      check(io[d] == 4'd0, "R9", d, int'(io[d]), 0);
    end
    rst_n = 1'b1;

    // table walk: forward (R2/R3/R4, cascade R8) and inverse (R7)
    for (int x = 0; x < 16; x++) begin
      drive(4'(x));
      for (int d = 0; d < N_DUT; d++) begin
        int p;
        p = d / 2;
        check(fo[d] == EXP_TBL[p][x], (d % 2) ? {req_of(p), "/R8"} : req_of(p),
              d, int'(fo[d]), int'(EXP_TBL[p][x]));
        check(io[d] == inv_exp(p, 4'(x)), "R7", d, int'(io[d]), int'(inv_exp(p, 4'(x))));
        seen[d][fo[d]] = 1'b1;
      end
    end
    // R1: every image hit exactly once
    for (int d = 0; d < N_DUT; d++) check(seen[d] == 16'hFFFF, "R1", d, int'(seen[d]), 16'hFFFF);

    // R7 roundtrip: feed forward result back
    for (int x = 0; x < 16; x++) begin
      drive(4'(x));
      @(posedge clk);
      for (int d = 0; d < N_DUT; d++) ii[d] = fo[d];
      @(negedge clk);
      for (int d = 0; d < N_DUT; d++) check(io[d] == 4'(x), "R7", d, int'(io[d]), x);
    end

    // R5/R6: adder truth table with ancilla 0, valid flag both ways
    for (int d = 0; d < N_DUT; d++) begin
      int p;
      p = d / 2;
      for (int o = 0; o < 8; o++) begin
        logic [2:0] ops;
        logic es, ec;
        ops = 3'(o);
        es  = ^ops;
        ec  = (ops[0] & ops[1]) | (ops[0] & ops[2]) | (ops[1] & ops[2]);
        drive(put_anc(p, ops, 1'b0));
        check(fo[d][1] == es, "R5", d, int'(fo[d][1]), int'(es));
        check(fo[d][0] == ec, "R5", d, int'(fo[d][0]), int'(ec));
        check(so[d] == es && co[d] == ec, "R6", d, int'({so[d], co[d]}), int'({es, ec}));
        check(vo[d] == 1'b1, "R6", d, int'(vo[d]), 1);
        drive(put_anc(p, ops, 1'b1));
        check(vo[d] == 1'b0, "R6", d, int'(vo[d]), 0);
        check(so[d] == fo[d][1] && co[d] == fo[d][0], "R6", d,
              int'({so[d], co[d]}), int'(fo[d][1:0]));
      end
    end

    // corner: all lines high, then back to zero in the next cycle (R9)
    drive(4'hF);
    for (int d = 0; d < N_DUT; d++)
      check(fo[d] == EXP_TBL[d/2][15], req_of(d/2), d, int'(fo[d]), int'(EXP_TBL[d/2][15]));
    drive(4'h0);
    for (int d = 0; d < N_DUT; d++) check(fo[d] == 4'd0, "R9", d, int'(fo[d]), 0);

    finish_run();
  end
endmodule